// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects twelve interrupt causes into latched request flags and decides which one the CPU should service next. Six peripheral pulses, four edge-detected pins, one keypad wake-up detector and one software break request each set their own request flag. Every maskable flag is gated by its own enable bit and by a global disable flag. The unmaskable break request ignores both gates. Among the sources that survive the gating, the one with the highest fixed priority wins.

When the CPU signals that it sits at an instruction boundary, the winning source is accepted. For one cycle the block raises a strobe that tells the CPU to save its state and jump. Alongside the strobe it presents the source number and the 16-bit address of the vector's low byte. On the same clock edge it clears that source's request flag and sets the global disable flag.

A small register port lets software inspect and change the state. Software can read the request, enable, edge-select and control bits. It can write the enables, edge selects and the disable flag. It can only clear request flags, never set them. The CPU core remains in charge of stacking, program-counter loading and reset sequencing.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the strobe is 0, the vector output is FFFC hex and the global disable flag reads 1. The request, enable and edge-select registers all read 0.
- R2: A maskable source is accepted only when its request flag is 1, its enable bit is 1, the disable flag is 0 and `cpu_ready` is 1. The strobe `irq_take` is high for exactly the one cycle after the clock edge that sampled those conditions.
- R3: In the request register, a written 0 clears that flag and a written 1 leaves it unchanged. If a set event and a clearing write hit the same flag on the same edge, the flag ends up set.
- R4: The break source (index 11) is accepted whenever its flag is set and `cpu_ready` is 1, regardless of its enable bit and of the disable flag.
- R5: When several sources are eligible, the lowest index is accepted first. The indexes are: 0 serial receive, 1 serial transmit, 2 pin 0, 3 pin 1, 4 key wake-up, 5 counter pin 0, 6 counter pin 1, 7 timer X, 8 timer A, 9 A/D done, 10 timer 1, 11 break.
- R6: For source k below 11, `irq_vec` is FFFA hex minus 2·k. For break, `irq_vec` is FFDC hex. `irq_id` and `irq_vec` keep their values until the next acceptance.
- R7: Acceptance sets the disable flag and clears the accepted request flag on the same edge that raises the strobe.
- R8: A one-cycle pulse on `periph_evt` sets one request flag. The bit-to-source mapping is: bit 0 to source 0, bit 1 to source 1, bit 2 to source 7, bit 3 to source 8, bit 4 to source 9, bit 5 to source 10.
- R9: `ext_pin` bits 0 to 3 drive sources 2, 3, 5 and 6 through a two-stage synchronizer. Edge-select bit k set to 0 selects the rising edge of that pin, and 1 selects the falling edge. An edge of the opposite direction sets nothing.
- R10: If a pin sits at a steady level, flipping its edge-select bit so that the current level now counts as the active side sets that pin's request flag.
- R11: The key wake-up source is set on a falling transition of the AND of the `key_lvl` bits whose `key_is_in` bit is 1. Bits whose `key_is_in` bit is 0 are ignored. Detection happens only while edge-select bit 4 is 1.
- R12: Register addresses are: 0 requests (bits 11:0), 1 enables (bits 11:0), 2 edge selects (bits 4:0), 3 control (bit 0 is the disable flag). Reads appear on `reg_rdata` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | Asynchronous pin levels for sources 2, 3, 5, 6 |
| key_lvl | input | PORT_W | Keypad port levels |
| key_is_in | input | PORT_W | 1 marks a keypad bit as an input taking part in the AND |
| periph_evt | input | 6 | Single-cycle peripheral event pulses |
| brk_req | input | 1 | Single-cycle software break request |
| cpu_ready | input | 1 | CPU is at an instruction boundary |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Registered read data |
| irq_take | output | 1 | One-cycle accept strobe, which is also the push request |
| irq_id | output | 4 | Index of the accepted source |
| irq_vec | output | 16 | Address of the accepted vector's low byte |

## Verification
An accepted interrupt shows up on `irq_take`, `irq_id` and `irq_vec` one edge after the cycle in which `cpu_ready` and an eligible flag coincide. A peripheral or break pulse reaches its flag on the next edge. A pin or keypad change needs three edges: two synchronizer stages plus the flag. An edge-select write can raise its flag one edge after the write. Register reads lag the address by one cycle. The bench drives inputs on the falling clock edge and compares accept outputs at the following falling edge, using a cycle-by-cycle reference model. Where the synchronizer delay matters, it waits four or more cycles before reading a register.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 12;
  localparam int IDW  = 4;
  localparam int NEXT = 4;
  localparam int NEVT = 6;

  localparam int SRC_RX   = 0;
  localparam int SRC_TX   = 1;
  localparam int SRC_PIN0 = 2;
  localparam int SRC_PIN1 = 3;
  localparam int SRC_KEY  = 4;
  localparam int SRC_CNT0 = 5;
  localparam int SRC_CNT1 = 6;
  localparam int SRC_TMX  = 7;
  localparam int SRC_TMA  = 8;
  localparam int SRC_ADC  = 9;
  localparam int SRC_TM1  = 10;
  localparam int SRC_BRK  = 11;

  localparam logic [15:0] VEC_RESET = 16'hFFFC;
  localparam logic [15:0] VEC_BRK   = 16'hFFDC;

  typedef enum logic [1:0] {
    RA_REQ  = 2'd0,
    RA_EN   = 2'd1,
    RA_EDGE = 2'd2,
    RA_CTL  = 2'd3
  } reg_addr_e;

  // Vectors of maskable sources step downward two bytes per index below reset.
  function automatic logic [15:0] vec_of(input logic [IDW-1:0] id);
    if (int'(id) == SRC_BRK) return VEC_BRK;
    return VEC_RESET - ((16'(id) + 16'd1) << 1);
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic pulse
);
  logic [SYNC_N-1:0] sh;
  logic              cur_x;
  logic              prev_x;

  // Both samples are seen through the polarity, so a polarity flip alone can fire.
  assign cur_x = sh[SYNC_N-1] ^ fall_sel;
  assign pulse = cur_x & ~prev_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      prev_x <= 1'b0;
    end else begin
      sh     <= {sh[SYNC_N-2:0], pin};
      prev_x <= cur_x;
    end
  end

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse || $changed(fall_sel) || $changed(sh[SYNC_N-1]));
endmodule

// File: rtl/irq_keyon.sv
module irq_keyon #(
  parameter int PORT_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] lvl,
  input  logic [PORT_W-1:0] is_in,
  input  logic              kon_en,
  output logic              pulse
);
  logic [SYNC_N-1:0][PORT_W-1:0] sh;
  logic                          and_now;
  logic                          and_prev;

  assign and_now = &(sh[SYNC_N-1] | ~is_in);
  assign pulse   = kon_en & and_prev & ~and_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '1;
      and_prev <= 1'b1;
    end else begin
      sh[0] <= lvl;
      for (int s = 1; s < SYNC_N; s++) sh[s] <= sh[s-1];
      and_prev <= and_now;
    end
  end

  a_r11_key_gated: assert property (@(posedge clk) disable iff (rst)
    pulse |-> kon_en && $past(and_now) && !and_now);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 12,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] cand,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEXT-1:0]   ext_pin,
  input  logic [PORT_W-1:0] key_lvl,
  input  logic [PORT_W-1:0] key_is_in,
  input  logic [NEVT-1:0]   periph_evt,
  input  logic              brk_req,
  input  logic              cpu_ready,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_take,
  output logic [IDW-1:0]    irq_id,
  output logic [15:0]       irq_vec
);
  localparam int EDGE_W = NEXT + 1;
  localparam logic [NSRC-1:0] BRK_MASK = NSRC'(1) << SRC_BRK;
  localparam int EXT_MAP [NEXT] = '{SRC_PIN0, SRC_PIN1, SRC_CNT0, SRC_CNT1};
  localparam int EVT_MAP [NEVT] = '{SRC_RX, SRC_TX, SRC_TMX, SRC_TMA, SRC_ADC, SRC_TM1};

  logic [NSRC-1:0]   req_q, en_q, set_vec, cand, acc_clr, sw_keep, req_d;
  logic [EDGE_W-1:0] edge_q;
  logic              gdis_q;
  logic [NEXT-1:0]   ext_det;
  logic              key_det;
  logic              hit, accept;
  logic [IDW-1:0]    pidx;

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    irq_sync_edge #(.SYNC_N(SYNC_N)) u_edge (
      .clk(clk), .rst(rst), .pin(ext_pin[k]), .fall_sel(edge_q[k]), .pulse(ext_det[k])
    );
  end

  irq_keyon #(.PORT_W(PORT_W), .SYNC_N(SYNC_N)) u_key (
    .clk(clk), .rst(rst), .lvl(key_lvl), .is_in(key_is_in),
    .kon_en(edge_q[NEXT]), .pulse(key_det)
  );

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < NEXT; k++) set_vec[EXT_MAP[k]] = ext_det[k];
    for (int e = 0; e < NEVT; e++) set_vec[EVT_MAP[e]] = periph_evt[e];
    set_vec[SRC_KEY] = key_det;
    set_vec[SRC_BRK] = brk_req;
  end

  assign cand = req_q & ((en_q & {NSRC{~gdis_q}}) | BRK_MASK);

  irq_prio_pick #(.N(NSRC)) u_pick (.cand(cand), .hit(hit), .idx(pidx));

  assign accept  = cpu_ready & hit;
  assign acc_clr = accept ? (NSRC'(1) << pidx) : '0;
  assign sw_keep = (reg_we && reg_addr == RA_REQ) ? reg_wdata : '1;
  // New events win over both software and acceptance clears.
  assign req_d   = (req_q & sw_keep & ~acc_clr) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      en_q      <= '0;
      edge_q    <= '0;
      gdis_q    <= 1'b1;
      irq_take  <= 1'b0;
      irq_id    <= '0;
      irq_vec   <= VEC_RESET;
      reg_rdata <= '0;
    end else begin
      req_q <= req_d;
      if (reg_we && reg_addr == RA_EN)   en_q   <= reg_wdata;
      if (reg_we && reg_addr == RA_EDGE) edge_q <= reg_wdata[EDGE_W-1:0];
      if (accept)                             gdis_q <= 1'b1;
      else if (reg_we && reg_addr == RA_CTL)  gdis_q <= reg_wdata[0];
      irq_take <= accept;
      if (accept) begin
        irq_id  <= pidx;
        irq_vec <= vec_of(pidx);
      end
      case (reg_addr_e'(reg_addr))
        RA_REQ:  reg_rdata <= req_q;
        RA_EN:   reg_rdata <= en_q;
        RA_EDGE: reg_rdata <= NSRC'(edge_q);
        default: reg_rdata <= NSRC'(gdis_q);
      endcase
    end
  end

  a_r2_take_needs_ready: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> $past(cpu_ready));

  a_r2_mask_respected: assert property (@(posedge clk) disable iff (rst)
    (irq_take && int'(irq_id) != SRC_BRK) |->
      (((($past(en_q) >> irq_id) & NSRC'(1)) != '0) && !$past(gdis_q)));

  a_r7_take_sets_disable: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> gdis_q);

  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    (req_q & ~$past(req_q) & ~$past(set_vec)) == '0);
endmodule

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ext_pin = '0;
  logic [7:0]  key_lvl = 8'hFF;
  logic [7:0]  key_is_in = 8'hFF;
  logic [5:0]  periph_evt = '0;
  logic        brk_req = 1'b0;
  logic        cpu_ready = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        irq_take;
  logic [3:0]  irq_id;
  logic [15:0] irq_vec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .key_lvl(key_lvl), .key_is_in(key_is_in),
    .periph_evt(periph_evt), .brk_req(brk_req), .cpu_ready(cpu_ready),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_take(irq_take), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  function automatic logic [15:0] exp_vec(input int id);
    if (id == 11) return 16'hFFDC;
    return 16'hFFFA - 16'(2 * id);
  endfunction

  function automatic int lowest(input logic [11:0] v);
    for (int i = 0; i < 12; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [11:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    @(negedge clk); periph_evt = v;
    @(negedge clk); periph_evt = '0;
  endtask

  initial begin
    logic [11:0] d;
    logic [11:0] reqm, enm;
    logic        gdm, etake, wq, wc;
    logic [3:0]  eid;
    logic [15:0] evec;
    logic [11:0] wdat, setv, cand, clr;
    int          pick;
    int          seed_dummy;

    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 take after reset", 32'(irq_take), 32'd0);
    chk("R1 vector after reset", 32'(irq_vec), 32'hFFFC);
    rd(2'd0, d); chk("R1 req reset", 32'(d), 32'd0);
    rd(2'd1, d); chk("R1 en reset", 32'(d), 32'd0);
    rd(2'd2, d); chk("R1 edge reset", 32'(d), 32'd0);
    rd(2'd3, d); chk("R1 R12 disable flag reset", 32'(d), 32'd1);

    wr(2'd0, 12'hFFF);
    rd(2'd0, d); chk("R3 write ones sets nothing", 32'(d), 32'd0);

    pulse_evt(6'b000001);
    pulse_evt(6'b100100);
    rd(2'd0, d); chk("R8 peripheral mapping", 32'(d), 32'h481);

    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 12'h000; periph_evt = 6'b000010;
    @(negedge clk);
    reg_we = 1'b0; periph_evt = '0;
    rd(2'd0, d); chk("R3 set wins over clear", 32'(d), 32'h002);

    cpu_ready = 1'b1;
    cyc(3); chk("R2 no take while disabled and masked", 32'(irq_take), 32'd0);
    wr(2'd1, 12'hFFF);
    cyc(3); chk("R2 no take while disable flag set", 32'(irq_take), 32'd0);
    wr(2'd3, 12'h000);
    @(negedge clk);
    chk("R2 take strobe", 32'(irq_take), 32'd1);
    chk("R5 id tx", 32'(irq_id), 32'd1);
    chk("R6 vec tx", 32'(irq_vec), 32'hFFF8);
    @(negedge clk);
    chk("R2 strobe one cycle", 32'(irq_take), 32'd0);
    rd(2'd3, d); chk("R7 disable set by accept", 32'(d), 32'd1);
    rd(2'd0, d); chk("R7 request cleared by accept", 32'(d), 32'd0);

    pulse_evt(6'b010001);
    wr(2'd3, 12'h000);
    @(negedge clk);
    chk("R5 first pick take", 32'(irq_take), 32'd1);
    chk("R5 first pick id 0", 32'(irq_id), 32'd0);
    chk("R6 vec rx", 32'(irq_vec), 32'hFFFA);
    wr(2'd3, 12'h000);
    @(negedge clk);
    chk("R5 second pick id 9", 32'(irq_id), 32'd9);
    chk("R6 vec adc", 32'(irq_vec), 32'hFFE8);
    @(negedge clk);
    chk("R6 id held", 32'(irq_id), 32'd9);
    chk("R6 vec held", 32'(irq_vec), 32'hFFE8);

    wr(2'd1, 12'h000);
    @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    @(negedge clk);
    chk("R4 break taken while masked", 32'(irq_take), 32'd1);
    chk("R4 break id", 32'(irq_id), 32'd11);
    chk("R6 break vec", 32'(irq_vec), 32'hFFDC);

    cpu_ready = 1'b0;
    @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    cyc(3); chk("R2 no take without ready", 32'(irq_take), 32'd0);
    rd(2'd0, d); chk("R2 break pending", 32'(d), 32'h800);
    cpu_ready = 1'b1;
    @(negedge clk);
    chk("R2 take once ready", 32'(irq_take), 32'd1);
    cpu_ready = 1'b0;

    wr(2'd0, 12'h000);
    @(negedge clk); ext_pin[0] = 1'b1;
    cyc(4);
    rd(2'd0, d); chk("R9 rising edge pin0", 32'(d), 32'h004);
    wr(2'd0, 12'h000);
    @(negedge clk); ext_pin[0] = 1'b0;
    cyc(4);
    rd(2'd0, d); chk("R9 falling ignored when rising selected", 32'(d), 32'h000);
    wr(2'd2, 12'h001);
    cyc(2);
    wr(2'd0, 12'h000);
    @(negedge clk); ext_pin[0] = 1'b1;
    cyc(4);
    rd(2'd0, d); chk("R9 rising ignored when falling selected", 32'(d), 32'h000);
    @(negedge clk); ext_pin[0] = 1'b0;
    cyc(4);
    rd(2'd0, d); chk("R9 falling edge pin0", 32'(d), 32'h004);

    wr(2'd2, 12'h000);
    cyc(2);
    wr(2'd0, 12'h000);
    wr(2'd2, 12'h002);
    cyc(2);
    rd(2'd0, d); chk("R10 edge flip raises pin1", 32'(d), 32'h008);

    wr(2'd0, 12'h000);
    wr(2'd2, 12'h012);
    @(negedge clk); key_is_in = 8'h0F; key_lvl = 8'h7F;
    cyc(5);
    rd(2'd0, d); chk("R11 output bit ignored", 32'(d), 32'h000);
    @(negedge clk); key_lvl = 8'h7D;
    cyc(5);
    rd(2'd0, d); chk("R11 key falling AND", 32'(d), 32'h010);
    wr(2'd0, 12'h000);
    @(negedge clk); key_lvl = 8'hFF;
    cyc(5);
    wr(2'd2, 12'h002);
    @(negedge clk); key_lvl = 8'hFB;
    cyc(5);
    rd(2'd0, d); chk("R11 key gated by enable", 32'(d), 32'h000);

    seed_dummy = $urandom(32'h5EED);
    wr(2'd0, 12'h000);
    wr(2'd3, 12'h001);
    enm = 12'($urandom);
    wr(2'd1, enm);
    reqm = '0; gdm = 1'b1; etake = 1'b0; eid = '0; evec = '0;
    @(negedge clk);
    for (int t = 0; t < 3000; t++) begin
      chk("R2 random take", 32'(irq_take), 32'(etake));
      if (etake) begin
        chk("R5 random id", 32'(irq_id), 32'(eid));
        chk("R6 random vec", 32'(irq_vec), 32'(evec));
      end
      setv = '0;
      for (int e = 0; e < 6; e++) periph_evt[e] = ($urandom % 8) == 0;
      brk_req   = ($urandom % 32) == 0;
      cpu_ready = $urandom % 2;
      wdat = 12'($urandom);
      case ($urandom % 8)
        0: begin wq = 1'b1; wc = 1'b0; end
        1: begin wq = 1'b0; wc = 1'b1; end
        default: begin wq = 1'b0; wc = 1'b0; end
      endcase
      reg_we = wq | wc;
      reg_addr = wq ? 2'd0 : 2'd3;
      reg_wdata = wq ? wdat : 12'h000;
      setv[0] = periph_evt[0]; setv[1] = periph_evt[1]; setv[7] = periph_evt[2];
      setv[8] = periph_evt[3]; setv[9] = periph_evt[4]; setv[10] = periph_evt[5];
      setv[11] = brk_req;
      cand = reqm & ((enm & {12{~gdm}}) | 12'h800);
      etake = cpu_ready && (cand != 0);
      clr = '0;
      if (etake) begin
        pick = lowest(cand);
        eid  = 4'(pick);
        evec = exp_vec(pick);
        clr  = 12'(1) << pick;
      end
      reqm = (reqm & (wq ? wdat : 12'hFFF) & ~clr) | setv;
      gdm  = etake ? 1'b1 : (wc ? 1'b0 : gdm);
      @(negedge clk);
    end
    reg_we = 1'b0; periph_evt = '0; brk_req = 1'b0; cpu_ready = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule